// File: doc/BRIEF.md
# Page Entry Permission Checker

This block holds one 64-bit page table entry and judges memory access requests against it. Each request states whether it is a read, a write or an instruction fetch, along with the current privilege ring (0 to 3, where 3 is user). The block tests the entry's present, writable, user-accessible and no-execute bits. It answers one cycle later with either a fault code or a grant.

A granted access sets the entry's accessed bit. A granted write also sets the dirty bit. When either bit goes from 0 to 1, the block pulses a write-back strobe so that the surrounding logic can store the changed entry back to memory. The block never clears those bits itself. Software replaces the held entry, and so clears status bits, through a separate load port.

A denied access leaves the entry untouched. All bits other than accessed and dirty pass through unchanged, including the three software-owned bits at positions 11:9.

Top module: `pte_guard`

## Requirements
- R1: When the present bit (bit 0) of the held entry is 0, every request gets fault code 1.
- R2: When the user bit (bit 2) is 0, a request from ring 3 gets fault code 2, while rings 0, 1 and 2 are not denied for privilege; when it is 1, all rings pass this check.
- R3: A write request (req_kind 1) to an entry whose writable bit (bit 1) is 0 gets fault code 3; reads (req_kind 0) and fetches (req_kind 2) are not affected by this bit.
- R4: A fetch request (req_kind 2) to an entry whose no-execute bit (bit 63) is 1 gets fault code 4; reads and writes are not affected by this bit.
- R5: When several faults apply, the code reported is the first of: absent (1), privilege (2), write-protect (3), no-execute (4).
- R6: A granted request reports code 0 with rsp_fault low, sets the accessed bit (bit 5), and for a write also sets the dirty bit (bit 6); every other bit of the entry, including bits 11:9, is unchanged.
- R7: wb_strobe pulses for one cycle with the response only when the accessed or dirty bit changes from 0 to 1.
- R8: A denied request leaves the entry unchanged and does not raise wb_strobe.
- R9: The block never clears the accessed or dirty bit; only a software load replaces the entry.
- R10: A software load (sw_load) replaces the held entry on the next edge, takes priority over a request in the same cycle, and that request gets no response.
- R11: After reset the held entry is all zeros and rsp_valid, rsp_fault, wb_strobe and rsp_code are 0.
- R12: The response (rsp_valid, rsp_fault, rsp_code, wb_strobe and the updated pte_out) appears on the edge that samples the request and lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request present this cycle |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch |
| req_ring | input | 2 | Current privilege ring, 3 is user |
| sw_load | input | 1 | Software replaces the held entry |
| sw_entry | input | 64 | Entry value written by software |
| rsp_valid | output | 1 | Response to the request of the previous cycle |
| rsp_fault | output | 1 | Request denied |
| rsp_code | output | 3 | Fault code, 0 when granted |
| wb_strobe | output | 1 | Entry changed and must be written back |
| pte_out | output | 64 | Currently held entry |

## Verification
Some properties are checked on every cycle:
- the absent and privilege fault codes,
- write-protect and no-execute reporting once higher-priority faults are excluded,
- that the strobe coincides with a real 0-to-1 change of the accessed or dirty bit,
- that denied requests keep the entry,
- that status bits never drop without a software load,
- that a load suppresses the response.

Other behaviour is only visible through the bench's scenarios:
- the full priority order with several faults present at once,
- exact entry values after grants, including pass-through of the software bits and the upper bits,
- the sequence where a status bit that is already set produces no strobe, is cleared by software, and is set again.

// File: rtl/pte_guard_pkg.sv
package pte_guard_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2
  } acc_kind_e;

  typedef enum logic [2:0] {
    FLT_NONE   = 3'd0,
    FLT_ABSENT = 3'd1,
    FLT_PRIV   = 3'd2,
    FLT_WPROT  = 3'd3,
    FLT_NOEXEC = 3'd4
  } fault_e;
endpackage

// File: rtl/pte_guard_check.sv
module pte_guard_check
  import pte_guard_pkg::*;
#(
  parameter int RING_W    = 2,
  parameter int USER_RING = 3
) (
  input  logic              present,
  input  logic              writable,
  input  logic              user_ok,
  input  logic              no_exec,
  input  logic [1:0]        kind,
  input  logic [RING_W-1:0] ring,
  output fault_e            fault
);
  localparam logic [RING_W-1:0] USER_LVL = RING_W'(USER_RING);

  logic is_write, is_fetch, is_user;

  always_comb begin
    is_write = (kind == ACC_WRITE);
    is_fetch = (kind == ACC_FETCH);
    is_user  = (ring == USER_LVL);
    if (!present)                 fault = FLT_ABSENT;
    else if (is_user && !user_ok) fault = FLT_PRIV;
    else if (is_write && !writable) fault = FLT_WPROT;
    else if (is_fetch && no_exec) fault = FLT_NOEXEC;
    else                          fault = FLT_NONE;
  end
endmodule

// File: rtl/pte_guard_update.sv
module pte_guard_update #(
  parameter int ENTRY_W = 64,
  parameter int B_ACC   = 5,
  parameter int B_DIRTY = 6
) (
  input  logic [ENTRY_W-1:0] cur,
  input  logic               is_write,
  output logic [ENTRY_W-1:0] nxt,
  output logic               changed
);
  always_comb begin
    nxt          = cur;
    nxt[B_ACC]   = 1'b1;
    if (is_write) nxt[B_DIRTY] = 1'b1;
    changed      = (nxt[B_ACC] != cur[B_ACC]) || (nxt[B_DIRTY] != cur[B_DIRTY]);
  end
endmodule

// File: rtl/pte_guard.sv
module pte_guard
  import pte_guard_pkg::*;
#(
  parameter int ENTRY_W   = 64,
  parameter int RING_W    = 2,
  parameter int USER_RING = 3,
  parameter int B_PRESENT = 0,
  parameter int B_WRITE   = 1,
  parameter int B_USER    = 2,
  parameter int B_ACC     = 5,
  parameter int B_DIRTY   = 6,
  parameter int B_NOEXEC  = 63
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [1:0]         req_kind,
  input  logic [RING_W-1:0]  req_ring,
  input  logic               sw_load,
  input  logic [ENTRY_W-1:0] sw_entry,
  output logic               rsp_valid,
  output logic               rsp_fault,
  output logic [2:0]         rsp_code,
  output logic               wb_strobe,
  output logic [ENTRY_W-1:0] pte_out
);
  logic [ENTRY_W-1:0] pte_q, pte_nxt;
  logic               grew;
  fault_e             fault;

  pte_guard_check #(.RING_W(RING_W), .USER_RING(USER_RING)) u_check (
    .present  (pte_q[B_PRESENT]),
    .writable (pte_q[B_WRITE]),
    .user_ok  (pte_q[B_USER]),
    .no_exec  (pte_q[B_NOEXEC]),
    .kind     (req_kind),
    .ring     (req_ring),
    .fault    (fault)
  );

  pte_guard_update #(.ENTRY_W(ENTRY_W), .B_ACC(B_ACC), .B_DIRTY(B_DIRTY)) u_update (
    .cur      (pte_q),
    .is_write (req_kind == ACC_WRITE),
    .nxt      (pte_nxt),
    .changed  (grew)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pte_q     <= '0;
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_code  <= FLT_NONE;
      wb_strobe <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_code  <= FLT_NONE;
      wb_strobe <= 1'b0;
      if (sw_load) begin
        pte_q <= sw_entry;
      end else if (req_valid) begin
        rsp_valid <= 1'b1;
        rsp_code  <= fault;
        rsp_fault <= (fault != FLT_NONE);
        if (fault == FLT_NONE) begin
          pte_q     <= pte_nxt;
          wb_strobe <= grew;
        end
      end
    end
  end

  assign pte_out = pte_q;
endmodule

// File: rtl/pte_guard_sva.sv
module pte_guard_sva #(
  parameter int ENTRY_W   = 64,
  parameter int RING_W    = 2,
  parameter int USER_RING = 3,
  parameter int B_PRESENT = 0,
  parameter int B_WRITE   = 1,
  parameter int B_USER    = 2,
  parameter int B_ACC     = 5,
  parameter int B_DIRTY   = 6,
  parameter int B_NOEXEC  = 63
) (
  input logic               clk,
  input logic               rst,
  input logic               req_valid,
  input logic [1:0]         req_kind,
  input logic [RING_W-1:0]  req_ring,
  input logic               sw_load,
  input logic               rsp_valid,
  input logic               rsp_fault,
  input logic [2:0]         rsp_code,
  input logic               wb_strobe,
  input logic [ENTRY_W-1:0] pte_out
);
  localparam logic [RING_W-1:0] USER_LVL = RING_W'(USER_RING);

  a_r1_absent_faults: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !$past(pte_out[B_PRESENT]) |-> rsp_code == 3'd1);

  a_r2_user_denied: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && $past(pte_out[B_PRESENT] && !pte_out[B_USER] && req_ring == USER_LVL)
      |-> rsp_code == 3'd2);

  a_r3_write_protect: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_code != 3'd1 && rsp_code != 3'd2 &&
      $past(req_kind == 2'd1 && !pte_out[B_WRITE]) |-> rsp_code == 3'd3);

  a_r4_no_exec: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_code != 3'd1 && rsp_code != 3'd2 &&
      $past(req_kind == 2'd2 && pte_out[B_NOEXEC]) |-> rsp_code == 3'd4);

  a_r7_strobe_real_change: assert property (@(posedge clk) disable iff (rst)
    wb_strobe |-> rsp_valid && !rsp_fault &&
      ((!$past(pte_out[B_ACC]) && pte_out[B_ACC]) ||
       (!$past(pte_out[B_DIRTY]) && pte_out[B_DIRTY])));

  a_r8_deny_keeps_entry: assert property (@(posedge clk) disable iff (rst)
    rsp_fault |-> pte_out == $past(pte_out) && !wb_strobe && rsp_code != 3'd0);

  a_r9_acc_sticky: assert property (@(posedge clk) disable iff (rst)
    !$past(sw_load) && $past(pte_out[B_ACC]) |-> pte_out[B_ACC]);

  a_r9_dirty_sticky: assert property (@(posedge clk) disable iff (rst)
    !$past(sw_load) && $past(pte_out[B_DIRTY]) |-> pte_out[B_DIRTY]);

  a_r10_load_wins: assert property (@(posedge clk) disable iff (rst)
    $past(sw_load) |-> !rsp_valid);

  a_r12_resp_follows_req: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(req_valid));
endmodule

bind pte_guard pte_guard_sva #(
  .ENTRY_W(ENTRY_W), .RING_W(RING_W), .USER_RING(USER_RING),
  .B_PRESENT(B_PRESENT), .B_WRITE(B_WRITE), .B_USER(B_USER),
  .B_ACC(B_ACC), .B_DIRTY(B_DIRTY), .B_NOEXEC(B_NOEXEC)
) u_sva (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
  .req_ring(req_ring), .sw_load(sw_load), .rsp_valid(rsp_valid),
  .rsp_fault(rsp_fault), .rsp_code(rsp_code), .wb_strobe(wb_strobe),
  .pte_out(pte_out)
);

// File: tb/pte_guard_tb.sv
module pte_guard_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = 2'd0;
  logic [1:0]  req_ring = 2'd0;
  logic        sw_load = 1'b0;
  logic [63:0] sw_entry = 64'h0;
  logic        rsp_valid, rsp_fault, wb_strobe;
  logic [2:0]  rsp_code;
  logic [63:0] pte_out;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pte_guard u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .req_ring(req_ring), .sw_load(sw_load), .sw_entry(sw_entry),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_code(rsp_code),
    .wb_strobe(wb_strobe), .pte_out(pte_out)
  );

  typedef struct packed {
    logic [63:0] ent;
    logic [1:0]  kind;
    logic [1:0]  ring;
    logic [2:0]  code;
    logic        wb;
    logic [63:0] exp;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{64'h0000_0000_0000_0000, 2'd0, 2'd0, 3'd1, 1'b0, 64'h0000_0000_0000_0000},
    '{64'h0000_0000_0000_0006, 2'd1, 2'd3, 3'd1, 1'b0, 64'h0000_0000_0000_0006},
    '{64'h0000_0000_0000_0003, 2'd0, 2'd3, 3'd2, 1'b0, 64'h0000_0000_0000_0003},
    '{64'h0000_0000_0000_0001, 2'd1, 2'd3, 3'd2, 1'b0, 64'h0000_0000_0000_0001},
    '{64'h0000_0000_0000_0005, 2'd1, 2'd3, 3'd3, 1'b0, 64'h0000_0000_0000_0005},
    '{64'h8000_0000_0000_0001, 2'd2, 2'd3, 3'd2, 1'b0, 64'h8000_0000_0000_0001},
    '{64'h8000_0000_0000_0005, 2'd2, 2'd3, 3'd4, 1'b0, 64'h8000_0000_0000_0005},
    '{64'h8000_0000_0000_0003, 2'd1, 2'd0, 3'd0, 1'b1, 64'h8000_0000_0000_0063},
    '{64'h0000_0000_0000_0007, 2'd0, 2'd3, 3'd0, 1'b1, 64'h0000_0000_0000_0027},
    '{64'h0000_0000_0000_0027, 2'd0, 2'd2, 3'd0, 1'b0, 64'h0000_0000_0000_0027},
    '{64'h0000_0000_0000_0027, 2'd1, 2'd1, 3'd0, 1'b1, 64'h0000_0000_0000_0067},
    '{64'h0000_0000_0000_0067, 2'd1, 2'd3, 3'd0, 1'b0, 64'h0000_0000_0000_0067},
    '{64'h0000_0000_0000_0E07, 2'd2, 2'd0, 3'd0, 1'b1, 64'h0000_0000_0000_0E27},
    '{64'h0000_0000_0000_0045, 2'd0, 2'd3, 3'd0, 1'b1, 64'h0000_0000_0000_0065},
    '{64'h7FFF_0000_0000_0E03, 2'd1, 2'd0, 3'd0, 1'b1, 64'h7FFF_0000_0000_0E63},
    '{64'h0000_0000_0000_0003, 2'd0, 2'd2, 3'd0, 1'b1, 64'h0000_0000_0000_0023}
  };

  function automatic string code_tag(input logic [2:0] c);
    case (c)
      3'd1: return "R1";
      3'd2: return "R2";
      3'd3: return "R3";
      3'd4: return "R4";
      default: return "R6";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic load(input logic [63:0] e);
    @(negedge clk);
    sw_load = 1'b1; sw_entry = e;
    @(negedge clk);
    sw_load = 1'b0;
  endtask

  task automatic access(input logic [1:0] k, input logic [1:0] r);
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_ring = r;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Checks the response visible in the cycle after a request (R12)
  task automatic expect_rsp(input string tag, input logic [2:0] code,
                            input logic wb, input logic [63:0] ent);
    chk({tag, " R12 rsp_valid"}, 64'(rsp_valid), 64'd1);
    chk({tag, " code"}, 64'(rsp_code), 64'(code));
    chk({tag, " fault flag"}, 64'(rsp_fault), 64'(code != 3'd0));
    chk({"R7 ", tag, " strobe"}, 64'(wb_strobe), 64'(wb));
    chk({(code != 3'd0) ? "R8 " : "R6 ", tag, " entry"}, pte_out, ent);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected<=20000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 entry", pte_out, 64'h0);
    chk("R11 rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R11 rsp_fault", 64'(rsp_fault), 64'd0);
    chk("R11 strobe", 64'(wb_strobe), 64'd0);
    chk("R11 code", 64'(rsp_code), 64'd0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      load(VEC[i].ent);
      chk("R10 load replaces entry", pte_out, VEC[i].ent);
      access(VEC[i].kind, VEC[i].ring);
      expect_rsp(code_tag(VEC[i].code), VEC[i].code, VEC[i].wb, VEC[i].exp);
      @(negedge clk);
      chk("R12 single-cycle response", 64'(rsp_valid), 64'd0);
    end

    // R5: priority with several faults present at once
    load(64'h8000_0000_0000_0000);   // absent, supervisor, read-only, no-exec
    access(2'd2, 2'd3);
    chk("R5 absent first", 64'(rsp_code), 64'd1);
    load(64'h8000_0000_0000_0001);   // present, supervisor, read-only, no-exec
    access(2'd1, 2'd3);
    chk("R5 privilege before write-protect", 64'(rsp_code), 64'd2);
    load(64'h8000_0000_0000_0005);   // user ok, read-only, no-exec
    access(2'd1, 2'd3);
    chk("R5 write-protect (write ignores NX)", 64'(rsp_code), 64'd3);
    access(2'd2, 2'd0);
    chk("R5 no-exec last", 64'(rsp_code), 64'd4);
    chk("R8 entry after fault", pte_out, 64'h8000_0000_0000_0005);

    // R9: sticky status bits, cleared only by software
    load(64'h0000_0000_0000_0007);
    access(2'd1, 2'd3);
    expect_rsp("R9 first write", 3'd0, 1'b1, 64'h67);
    access(2'd0, 2'd3);
    expect_rsp("R9 read keeps D", 3'd0, 1'b0, 64'h67);
    load(64'h0000_0000_0000_0007);
    chk("R9 software clears A and D", pte_out, 64'h7);
    access(2'd2, 2'd3);
    expect_rsp("R9 fetch after clear", 3'd0, 1'b1, 64'h27);

    // R10: load and request in the same cycle
    @(negedge clk);
    sw_load = 1'b1; sw_entry = 64'h0000_0000_0000_0000;
    req_valid = 1'b1; req_kind = 2'd1; req_ring = 2'd0;
    @(negedge clk);
    sw_load = 1'b0; req_valid = 1'b0;
    chk("R10 request dropped", 64'(rsp_valid), 64'd0);
    chk("R10 strobe low", 64'(wb_strobe), 64'd0);
    chk("R10 loaded value", pte_out, 64'h0);

    // R12: idle cycle gives no response
    @(negedge clk);
    chk("R12 idle", 64'(rsp_valid), 64'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule